// File: doc/BRIEF.md
# Serial Clock Mode and De-emphasis Control

This block watches one input pin that serves two purposes. When an outside source drives it as a serial bit clock, the block sees a burst of rising edges within one half of the frame clock. It then locks into external bit-clock mode, and only power-down releases that mode. When nothing toggles the pin, it is a static level. The block samples that level on falling edges of the frame clock. A level that holds for a full run of those samples turns the de-emphasis filter enable on (low) or off (high).

All logic runs on the master clock. The pin and the frame clock each pass through a two-flop synchronizer before any edge is detected.

In internal mode the block divides the master clock to make a bit clock, and every frame-clock edge restarts that divider. A select output and a routed bit clock output give the data shifter the synchronized external pin in external mode, or the internal clock otherwise. Power-down acts as an asynchronous reset. It returns the block to internal mode with de-emphasis off.

Top module: `sclk_mode_ctrl`

## Requirements
- R1: Four rising edges of the pin within one phase of the frame clock (between two consecutive frame edges) set `ext_mode` to 1 within 6 master clock cycles of the fourth edge.
- R2: Fewer than four rising edges in a phase leave `ext_mode` at 0. The rise counter restarts at every frame edge, so rises split across a frame edge (for example 2+2 or 3+1) are not added together.
- R3: Once set, `ext_mode` stays 1 through any pin or frame activity until `pwr_down` is asserted.
- R4: While `pwr_down` is 1, and directly after it is released, `ext_mode`=0, `deemph_en`=0 and `bclk_sel`=0 (internal).
- R5: The pin sampled low on 8 consecutive falling frame edges sets `deemph_en` to 1. After only 7 such samples it is still 0.
- R6: The pin sampled high on 8 consecutive falling frame edges clears `deemph_en` to 0. After only 7 such samples it keeps its value.
- R7: A sample whose level differs from the previous sample restarts the run count. After 7 lows, 1 high and 7 lows, `deemph_en` stays 0, and one more low sets it.
- R8: While `ext_mode` is 1, `deemph_en` is 0 whatever the qualified pin level.
- R9: In internal mode `bclk_out` toggles every HALF_DIV master cycles (default 2, giving 16 rising edges in 64 cycles). A frame edge restarts it low for HALF_DIV cycles.
- R10: In external mode `bclk_sel`=1 and `bclk_out` follows the pin with a two-cycle synchronizer delay.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| mclk | input | 1 | Master clock |
| pwr_down | input | 1 | Power-down, active high, asynchronous reset |
| frame_clk | input | 1 | Frame (word select) clock |
| shared_pin | input | 1 | Dual-use pin: external bit clock or static de-emphasis level |
| ext_mode | output | 1 | 1 when external bit-clock mode is locked |
| deemph_en | output | 1 | De-emphasis filter enable |
| bclk_sel | output | 1 | Bit clock source for the shifter: 0 internal, 1 external |
| bclk_out | output | 1 | Routed bit clock |

## Verification
The assertions check these rules on every cycle:
- the external mode never drops outside power-down;
- the rise counter restarts at each frame edge;
- the de-emphasis state moves only on a falling frame edge, and its run count never exceeds its limit;
- the internal bit clock restarts low on a frame edge and holds between divider wraps.

Only the bench's scenarios show the threshold counts: that exactly four rises in one phase are needed and that split bursts do not count. The same holds for the seven-versus-eight boundary of the de-emphasis run and the restart after a level change. They also cover the forcing of de-emphasis off in external mode and the routed clock's rate and latency.

// File: rtl/sclk_mode_pkg.sv
package sclk_mode_pkg;

  typedef enum logic {
    BCLK_INT = 1'b0,
    BCLK_EXT = 1'b1
  } bclk_src_e;

  // Next value of a same-level run counter that saturates at lim.
  function automatic int run_next(input int run, input bit same, input int lim);
    if (!same) return 1;
    if (run >= lim) return lim;
    return run + 1;
  endfunction

  // Next value of a rise counter within one frame phase.
  function automatic int rise_next(input int cnt, input bit rise, input bit restart, input int lim);
    if (restart) return rise ? 1 : 0;
    if (rise && cnt < lim) return cnt + 1;
    return cnt;
  endfunction

endpackage

// File: rtl/sync_edge.sv
module sync_edge #(
  parameter int STAGES = 2,
  parameter bit RST_VAL = 1'b0
) (
  input  logic clk,
  input  logic rst,
  input  logic din,
  output logic level,
  output logic level_d
);
  logic [STAGES-1:0] sh;

  always_ff @(posedge clk or posedge rst) begin
    if (rst) begin
      sh      <= {STAGES{RST_VAL}};
      level_d <= RST_VAL;
    end else begin
      sh      <= {sh[STAGES-2:0], din};
      level_d <= sh[STAGES-1];
    end
  end

  assign level = sh[STAGES-1];
endmodule

// File: rtl/mode_detect.sv
module mode_detect
  import sclk_mode_pkg::*;
#(
  parameter int RISES_NEEDED = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic pin_rise,
  input  logic frame_edge,
  output logic ext_mode
);
  localparam int CW = $clog2(RISES_NEEDED + 1);

  logic [CW-1:0] rise_cnt;
  logic          lock_hit;

  assign lock_hit = pin_rise && !frame_edge && (int'(rise_cnt) == RISES_NEEDED - 1);

  always_ff @(posedge clk or posedge rst) begin
    if (rst) begin
      rise_cnt <= '0;
      ext_mode <= 1'b0;
    end else begin
      rise_cnt <= CW'(rise_next(int'(rise_cnt), pin_rise, frame_edge, RISES_NEEDED));
      if (lock_hit) ext_mode <= 1'b1;
    end
  end

  // R1
  lock_entry_chk: assert property (@(posedge clk) disable iff (rst)
    lock_hit |=> ext_mode);

  // R2
  phase_restart_chk: assert property (@(posedge clk) disable iff (rst)
    frame_edge |=> (int'(rise_cnt) <= 1));

  // R3
  sticky_ext_chk: assert property (@(posedge clk) disable iff (rst)
    ext_mode |=> ext_mode);
endmodule

// File: rtl/deemph_qual.sv
module deemph_qual
  import sclk_mode_pkg::*;
#(
  parameter int RUN_LEN = 8
) (
  input  logic clk,
  input  logic rst,
  input  logic frame_fall,
  input  logic pin_level,
  output logic dem_state
);
  localparam int RW = $clog2(RUN_LEN + 1);

  logic [RW-1:0] run;
  logic          last_lvl;
  logic          same_lvl;
  logic [RW-1:0] run_nx;

  assign same_lvl = (run != '0) && (pin_level == last_lvl);
  assign run_nx   = RW'(run_next(int'(run), same_lvl, RUN_LEN));

  always_ff @(posedge clk or posedge rst) begin
    if (rst) begin
      run       <= '0;
      last_lvl  <= 1'b1;
      dem_state <= 1'b0;
    end else if (frame_fall) begin
      run      <= run_nx;
      last_lvl <= pin_level;
      if (int'(run_nx) == RUN_LEN) dem_state <= ~pin_level;
    end
  end

  // R5 R6
  dem_on_fall_only_chk: assert property (@(posedge clk) disable iff (rst)
    !frame_fall |=> $stable(dem_state));

  // R7
  run_bound_chk: assert property (@(posedge clk) disable iff (rst)
    int'(run) <= RUN_LEN);
endmodule

// File: rtl/bclk_gen.sv
module bclk_gen #(
  parameter int HALF_DIV = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic restart,
  output logic bclk
);
  localparam int DW = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;

  logic [DW-1:0] div_cnt;
  logic          wrap;

  assign wrap = (int'(div_cnt) == HALF_DIV - 1);

  always_ff @(posedge clk or posedge rst) begin
    if (rst) begin
      div_cnt <= '0;
      bclk    <= 1'b0;
    end else if (restart) begin
      div_cnt <= '0;
      bclk    <= 1'b0;
    end else if (wrap) begin
      div_cnt <= '0;
      bclk    <= ~bclk;
    end else begin
      div_cnt <= div_cnt + 1'b1;
    end
  end

  // R9
  restart_low_chk: assert property (@(posedge clk) disable iff (rst)
    restart |=> (!bclk && div_cnt == '0));

  // R9
  hold_between_wraps_chk: assert property (@(posedge clk) disable iff (rst)
    (!restart && !wrap) |=> $stable(bclk));
endmodule

// File: rtl/sclk_mode_ctrl.sv
module sclk_mode_ctrl
  import sclk_mode_pkg::*;
#(
  parameter int SYNC_STAGES  = 2,
  parameter int RISES_NEEDED = 4,
  parameter int RUN_LEN      = 8,
  parameter int HALF_DIV     = 2
) (
  input  logic mclk,
  input  logic pwr_down,
  input  logic frame_clk,
  input  logic shared_pin,
  output logic ext_mode,
  output logic deemph_en,
  output logic bclk_sel,
  output logic bclk_out
);
  logic pin_lvl, pin_prev, frm_lvl, frm_prev;
  logic pin_rise, frame_edge, frame_fall;
  logic dem_state, bclk_int;
  bclk_src_e src;

  sync_edge #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_pin_sync (
    .clk(mclk), .rst(pwr_down), .din(shared_pin), .level(pin_lvl), .level_d(pin_prev));

  sync_edge #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_frm_sync (
    .clk(mclk), .rst(pwr_down), .din(frame_clk), .level(frm_lvl), .level_d(frm_prev));

  assign pin_rise   = pin_lvl && !pin_prev;
  assign frame_edge = frm_lvl ^ frm_prev;
  assign frame_fall = !frm_lvl && frm_prev;

  mode_detect #(.RISES_NEEDED(RISES_NEEDED)) u_mode (
    .clk(mclk), .rst(pwr_down), .pin_rise(pin_rise),
    .frame_edge(frame_edge), .ext_mode(ext_mode));

  deemph_qual #(.RUN_LEN(RUN_LEN)) u_dem (
    .clk(mclk), .rst(pwr_down), .frame_fall(frame_fall),
    .pin_level(pin_lvl), .dem_state(dem_state));

  bclk_gen #(.HALF_DIV(HALF_DIV)) u_bclk (
    .clk(mclk), .rst(pwr_down), .restart(frame_edge), .bclk(bclk_int));

  assign src       = ext_mode ? BCLK_EXT : BCLK_INT;
  assign bclk_sel  = (src == BCLK_EXT);
  assign bclk_out  = (src == BCLK_EXT) ? pin_lvl : bclk_int;
  assign deemph_en = dem_state && !ext_mode;

  // R8
  ext_blocks_dem_chk: assert property (@(posedge mclk) disable iff (pwr_down)
    ($rose(ext_mode) && dem_state) |-> !deemph_en);
endmodule

// File: tb/sim_sclk_mode_ctrl.sv
`timescale 1ns/1ps
module sim_sclk_mode_ctrl;
  localparam int HALF = 2;

  logic mclk = 1'b0;
  logic pwr_down = 1'b1;
  logic frame_clk = 1'b0;
  logic shared_pin = 1'b0;
  logic ext_mode, deemph_en, bclk_sel, bclk_out;
  int n_run = 0;
  int n_fail = 0;

  always #2.5 mclk = ~mclk;

  sclk_mode_ctrl #(.HALF_DIV(HALF)) u0 (
    .mclk(mclk), .pwr_down(pwr_down), .frame_clk(frame_clk), .shared_pin(shared_pin),
    .ext_mode(ext_mode), .deemph_en(deemph_en), .bclk_sel(bclk_sel), .bclk_out(bclk_out));

  // {expect_ext, rises before frame edge, rises after frame edge}
  localparam logic [8:0] VEC [8] = '{
    {1'b0, 4'd3, 4'd0}, {1'b1, 4'd4, 4'd0}, {1'b0, 4'd2, 4'd2}, {1'b0, 4'd3, 4'd1},
    {1'b1, 4'd1, 4'd4}, {1'b0, 4'd0, 4'd0}, {1'b1, 4'd6, 4'd0}, {1'b0, 4'd3, 4'd3}};

  task automatic tick(input int n);
    repeat (n) @(negedge mclk);
  endtask

  task automatic chk(input string tag, input int act, input int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic pdown();
    pwr_down = 1'b1; tick(3); pwr_down = 1'b0; tick(3);
  endtask

  task automatic pulses(input int n);
    for (int i = 0; i < n; i++) begin
      shared_pin = 1'b1; tick(4); shared_pin = 1'b0; tick(4);
    end
  endtask

  task automatic one_fall(input logic lvl);
    shared_pin = lvl; frame_clk = 1'b1; tick(8); frame_clk = 1'b0; tick(8);
  endtask

  initial begin
    #(5.0 * 200000);
    n_fail++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    tick(2);
    // R4: state held in power-down
    chk("R4 ext in pdown", ext_mode, 0);
    chk("R4 deemph in pdown", deemph_en, 0);
    chk("R4 sel in pdown", bclk_sel, 0);
    pwr_down = 1'b0; tick(3);
    chk("R4 ext after release", ext_mode, 0);

    // R1 R2: table of rise bursts around a frame edge
    foreach (VEC[k]) begin
      pdown();
      tick(4);
      pulses(int'(VEC[k][7:4]));
      frame_clk = ~frame_clk; tick(4);
      pulses(int'(VEC[k][3:0]));
      tick(6);
      chk(VEC[k][8] ? "R1 burst locks ext" : "R2 short/split burst", ext_mode, int'(VEC[k][8]));
      chk("R10 sel follows mode", bclk_sel, int'(VEC[k][8]));
    end

    // R5 R6 R7: de-emphasis qualification
    pdown(); frame_clk = 1'b0; tick(2);
    for (int i = 0; i < 7; i++) one_fall(1'b0);
    chk("R5 seven lows", deemph_en, 0);
    one_fall(1'b0);
    chk("R5 eighth low", deemph_en, 1);
    for (int i = 0; i < 7; i++) one_fall(1'b1);
    chk("R6 seven highs", deemph_en, 1);
    one_fall(1'b1);
    chk("R6 eighth high", deemph_en, 0);
    for (int i = 0; i < 7; i++) one_fall(1'b0);
    one_fall(1'b1);
    for (int i = 0; i < 7; i++) one_fall(1'b0);
    chk("R7 run broken", deemph_en, 0);
    one_fall(1'b0);
    chk("R7 run completes", deemph_en, 1);

    // R8 R3: enter external mode with de-emphasis qualified on
    shared_pin = 1'b0; tick(2);
    pulses(4); tick(4);
    chk("R8 ext entered", ext_mode, 1);
    chk("R8 deemph forced off", deemph_en, 0);
    for (int i = 0; i < 3; i++) one_fall(1'b0);
    pulses(2); tick(4);
    chk("R3 ext sticky", ext_mode, 1);
    chk("R8 deemph still off", deemph_en, 0);

    // R10: routed clock follows pin
    shared_pin = 1'b1; tick(3);
    chk("R10 bclk high", bclk_out, 1);
    shared_pin = 1'b0; tick(3);
    chk("R10 bclk low", bclk_out, 0);

    // R4: power-down clears everything
    pdown();
    chk("R4 ext cleared", ext_mode, 0);
    chk("R4 deemph cleared", deemph_en, 0);
    chk("R4 sel internal", bclk_sel, 0);

    // R9: internal bit clock rate and restart
    tick(10);
    begin
      int rises = 0;
      logic prev = bclk_out;
      for (int i = 0; i < 64; i++) begin
        tick(1);
        if (bclk_out && !prev) rises++;
        prev = bclk_out;
      end
      chk("R9 rate", rises, 64 / (2 * HALF));
    end
    frame_clk = ~frame_clk;
    tick(3);
    for (int i = 0; i < HALF; i++) begin
      chk("R9 restart low", bclk_out, 0);
      tick(1);
    end
    chk("R9 first high", bclk_out, 1);

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule